// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is a single timer channel with a small word-addressed register interface. A 32-bit counter steps down by one on every prescaled tick while the channel's run input is high. When a tick arrives while the counter already reads zero, the counter is refilled from a reload register and a sticky underflow flag is raised. The flag drives an interrupt line through an enable bit held in the control word.

Software programs the reload value, may load the counter directly, and chooses one of five prescale divisors (4, 16, 64, 256 or 1024 input clocks per tick). It acknowledges an underflow by writing the control word with the flag bit at zero. An optional capture register can be kept or left out of the build with a parameter. Reads are combinational on the current address.

Top module: `dntimer_chan`

## Requirements
- R1: After reset the reload and counter registers read 0xFFFFFFFF, the control register reads 0 and irq_o is low.
- R2: The word index is byte address bits [3:2]: index 0 is reload, 1 is counter, 2 is control and 3 is capture. Address bits [1:0] are ignored.
- R3: Control bits [2:0] pick the prescale. Values 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks. The first tick comes that many clocks after run_i rises or after any control write.
- R4: Prescale values 5, 6 and 7 are reserved. With one of them selected, no tick is made and the counter holds its value.
- R5: On a tick with the counter at 0, the counter takes the reload value and the underflow flag (read at control bit 8) is set at the same clock edge. On any other tick the counter decrements by one.
- R6: irq_o is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: A control write with bit 8 at 0 clears the flag, and one with bit 8 at 1 leaves it as it is. If an underflow and a clearing write fall on the same edge, the flag ends set.
- R8: A control read returns the stored bits [7:0], the live flag at bit 8, and 0 in bit 9 and in bits [31:10], whatever was written there.
- R9: With HAS_CAPT=1 the capture register is read/write and resets to 0. With HAS_CAPT=0 it reads 0 and writes to it have no effect.
- R10: A counter write takes effect at the next edge and wins over a tick on that edge. A reload write changes only the value loaded at later underflows.
- R11: While run_i is low the counter holds its value and is not reloaded. The prescale phase restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address; bits [3:2] select the word |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i (combinational) |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The collision that matters is an underflow tick landing on the same edge as a control write that clears the flag. That write also restarts the prescaler, so it interacts with the tick twice. The bench walks the counter to zero and watches its own model of the prescale phase. It then issues the clearing write on exactly the edge that carries the underflow. It judges the result by reading the control word back: bit 8 must still be set and the counter must hold the reload value. Random traffic adds further same-edge overlaps of counter writes with ticks, and these are compared edge by edge against the bench model.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam int unsigned WIDX_RELOAD = 0;
  localparam int unsigned WIDX_COUNT  = 1;
  localparam int unsigned WIDX_CTRL   = 2;
  localparam int unsigned WIDX_CAPT   = 3;

  localparam int unsigned CTRL_W      = 8;  // stored control bits
  localparam int unsigned BIT_IE      = 5;
  localparam int unsigned BIT_UF      = 8;

  localparam int unsigned PSC_SEL_W   = 3;
  localparam int unsigned PSC_NUM     = 5;  // legal divisors
  localparam int unsigned PSC_BASE_LG = 2;  // smallest divisor = 4
  localparam int unsigned PSC_STEP_LG = 2;  // ratio between divisors = 4

  typedef struct packed {
    logic [1:0] icap_mode;
    logic       uf_ie;
    logic [1:0] clk_edge;
    logic [2:0] psc_sel;
  } ctrl_t;
endpackage

// File: rtl/dntimer_prescale.sv
module dntimer_prescale
  import dntimer_pkg::*;
#(
  parameter int unsigned NUM_DIV = PSC_NUM,
  parameter int unsigned BASE_LG = PSC_BASE_LG,
  parameter int unsigned STEP_LG = PSC_STEP_LG,
  parameter int unsigned SEL_W   = PSC_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = BASE_LG + STEP_LG * (NUM_DIV - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_DIV-1:0] hit;
  logic               sel_ok;

  assign sel_ok = (32'(sel_i) < NUM_DIV);

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << (BASE_LG + STEP_LG * g)) - 64'd1);
    assign hit[g] = (sel_i == SEL_W'(g)) && (cnt_q == LAST);
  end

  assign tick_o = run_i && sel_ok && (|hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || restart_i || !sel_ok || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dntimer_core.sv
module dntimer_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cnt_we_i,
  input  logic          rld_we_i,
  input  logic          flag_clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          flag_o
);
  logic [DW-1:0] cnt_q, rld_q;
  logic          flag_q, uf;

  assign uf = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      rld_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (rld_we_i) rld_q <= wdata_i;
      if (cnt_we_i)    cnt_q <= wdata_i;
      else if (uf)     cnt_q <= rld_q;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
      // a fresh underflow outranks an acknowledge on the same edge
      if (uf)              flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dntimer_regs.sv
module dntimer_regs
  import dntimer_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter bit          HAS_CAPT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] rld_i,
  input  logic          flag_i,
  output ctrl_t         ctrl_o,
  output logic          ctrl_wr_o,
  output logic          cnt_we_o,
  output logic          rld_we_o,
  output logic          flag_clr_o,
  output logic [DW-1:0] rdata_o
);
  logic          wr;
  ctrl_t         ctrl_q;
  logic [DW-1:0] capt_rd;

  assign wr         = req_i && we_i;
  assign rld_we_o   = wr && (widx_i == 2'(WIDX_RELOAD));
  assign cnt_we_o   = wr && (widx_i == 2'(WIDX_COUNT));
  assign ctrl_wr_o  = wr && (widx_i == 2'(WIDX_CTRL));
  assign flag_clr_o = ctrl_wr_o && !wdata_i[BIT_UF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_o) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  if (HAS_CAPT) begin : g_capt
    logic [DW-1:0] capt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) capt_q <= '0;
      else if (wr && (widx_i == 2'(WIDX_CAPT))) capt_q <= wdata_i;
    end
    assign capt_rd = capt_q;
  end else begin : g_nocapt
    assign capt_rd = '0;
  end

  always_comb begin
    unique case (widx_i)
      2'(WIDX_RELOAD): rdata_o = rld_i;
      2'(WIDX_COUNT):  rdata_o = cnt_i;
      2'(WIDX_CTRL):   rdata_o = DW'({flag_i, ctrl_q});
      default:         rdata_o = capt_rd;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
  import dntimer_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter bit          HAS_CAPT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  ctrl_t         ctrl_val;
  logic          ctrl_wr, cnt_we, rld_we, flag_clr, tick, flag;
  logic [DW-1:0] cnt_val, rld_val;
  logic [1:0]    unused_addr_lo;

  assign unused_addr_lo = addr_i[1:0];

  dntimer_regs #(.DW(DW), .HAS_CAPT(HAS_CAPT)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i,
    .widx_i     (addr_i[3:2]),
    .wdata_i,
    .cnt_i      (cnt_val),
    .rld_i      (rld_val),
    .flag_i     (flag),
    .ctrl_o     (ctrl_val),
    .ctrl_wr_o  (ctrl_wr),
    .cnt_we_o   (cnt_we),
    .rld_we_o   (rld_we),
    .flag_clr_o (flag_clr),
    .rdata_o
  );

  dntimer_prescale u_psc (
    .clk_i, .rst_ni, .run_i,
    .restart_i (ctrl_wr),
    .sel_i     (ctrl_val.psc_sel),
    .tick_o    (tick)
  );

  dntimer_core #(.DW(DW)) u_core (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .cnt_we_i   (cnt_we),
    .rld_we_i   (rld_we),
    .flag_clr_i (flag_clr),
    .wdata_i,
    .cnt_o      (cnt_val),
    .rld_o      (rld_val),
    .flag_o     (flag)
  );

  assign irq_o = flag && ctrl_val.uf_ie;
endmodule

// File: rtl/dntimer_chan_chk.sv
module dntimer_chan_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              irq_o,
  input logic              tick,
  input logic              flag,
  input logic [7:0]        ctrl_bits,
  input logic [DW-1:0]     cnt_val,
  input logic [DW-1:0]     rld_val
);
  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = req_i && we_i && (addr_i[3:2] == 2'd1);
  assign ctrl_wr = req_i && we_i && (addr_i[3:2] == 2'd2);

  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag && ctrl_bits[5]));

  assert_uf_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_val == '0 && !cnt_wr) |=> (flag && cnt_val == $past(rld_val)));

  assert_resv_psc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_bits[2:0] > 3'd4) |-> !tick);

  assert_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr) |=> $stable(cnt_val));

  assert_flag_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[8] && flag) |=> flag);

  assert_no_tick_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick);
endmodule

bind dntimer_chan dntimer_chan_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .run_i, .req_i, .we_i, .addr_i, .wdata_i, .irq_o,
  .tick      (tick),
  .flag      (flag),
  .ctrl_bits (ctrl_val),
  .cnt_val   (cnt_val),
  .rld_val   (rld_val)
);

// File: tb/dntimer_chan_test.sv
module dntimer_chan_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        run = 1'b0, req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] m_rld, m_cnt, m_capt;
  logic [7:0]  m_ctrl;
  logic        m_flag;
  int          m_pc;

  always #(CLK_P/2) clk = ~clk;

  dntimer_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // R3/R4: clocks per tick, 0 for reserved selections
  function automatic int f_div(input logic [2:0] s);
    return (s <= 3'd4) ? (4 << (2 * int'(s))) : 0;
  endfunction

  // R2/R8/R9: expected read value for a word index
  function automatic logic [31:0] f_read(input logic [1:0] idx);
    case (idx)
      2'd0: return m_rld;
      2'd1: return m_cnt;
      2'd2: return {23'd0, m_flag, m_ctrl};
      default: return m_capt;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rld = '1; m_cnt = '1; m_capt = '0; m_ctrl = '0; m_flag = 1'b0; m_pc = 0;
    end else begin
      logic wr, tk, uf, cw;
      int dv;
      wr = req && we;
      dv = f_div(m_ctrl[2:0]);
      tk = run && dv != 0 && m_pc == dv - 1;
      uf = tk && m_cnt == 0;
      cw = wr && addr[3:2] == 2'd2;
      if (wr && addr[3:2] == 2'd1) m_cnt = wdata;
      else if (uf) m_cnt = m_rld;
      else if (tk) m_cnt = m_cnt - 1;
      if (wr && addr[3:2] == 2'd0) m_rld = wdata;
      if (uf) m_flag = 1'b1;
      else if (cw && !wdata[8]) m_flag = 1'b0;
      if (cw) m_ctrl = wdata[7:0];
      if (wr && addr[3:2] == 2'd3) m_capt = wdata;
      m_pc = (!run || cw || dv == 0 || tk) ? 0 : m_pc + 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] idx);
    case (idx)
      2'd0: return "R10 reload";
      2'd1: return "R5 counter";
      2'd2: return "R8 control";
      default: return "R9 capture";
    endcase
  endfunction

  // drive at negedge, compare at the next negedge
  task automatic step(input logic rq, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic rn, input string tag);
    req = rq; we = w; addr = a; wdata = d; run = rn;
    @(posedge clk);
    @(negedge clk);
    check(rdata, f_read(a[3:2]), (tag == "") ? tag_of(a[3:2]) : tag);
    check({31'd0, irq}, {31'd0, m_flag & m_ctrl[5]}, "R6 irq");
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic rn, input string tag);
    step(1'b1, 1'b1, a, d, rn, tag);
  endtask

  task automatic idle(input int n, input logic [3:0] a, input logic rn, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, a, '0, rn, tag);
  endtask

  initial begin
    #(CLK_P * 120000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit hit;
    void'($urandom(32'h5eed_71e2));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 word decode (address low bits ignored)
    check(rdata, 32'hFFFF_FFFF, "R1 reload");
    check({31'd0, irq}, 32'd0, "R1 irq");
    idle(1, 4'h4, 1'b0, "R1 counter");
    idle(1, 4'h9, 1'b0, "R1 control");
    idle(1, 4'hF, 1'b0, "R2 capture");

    // R3: divide by 4 then 16, counter read every clock
    wr_reg(4'h0, 32'd5, 1'b0, "R10 reload wr");
    wr_reg(4'h4, 32'd3, 1'b0, "R10 counter wr");
    wr_reg(4'h8, 32'h20, 1'b0, "R3 ctrl sel0");
    idle(30, 4'h4, 1'b1, "R3 div4");
    wr_reg(4'h8, 32'h21, 1'b1, "R3 ctrl sel1");
    idle(70, 4'h4, 1'b1, "R3 div16");
    wr_reg(4'h8, 32'h124, 1'b1, "R3 ctrl sel4");
    idle(2100, 4'h4, 1'b1, "R3 div1024");

    // R4: reserved selections freeze the count
    wr_reg(4'h8, 32'h25, 1'b1, "R4 sel5");
    idle(40, 4'h4, 1'b1, "R4 frozen");
    wr_reg(4'h8, 32'h127, 1'b1, "R4 sel7");
    idle(40, 4'h4, 1'b1, "R4 frozen");

    // R11: run low holds counter
    wr_reg(4'h8, 32'h120, 1'b1, "R8 ctrl");
    idle(10, 4'h4, 1'b1, "");
    idle(25, 4'h4, 1'b0, "R11 hold");
    idle(10, 4'h4, 1'b1, "R11 resume");

    // R8: upper and capture-flag bits read back as 0
    wr_reg(4'h8, 32'hFFFF_FEE0, 1'b0, "R8 mask");
    idle(1, 4'h8, 1'b0, "R8 mask");

    // R9: capture read/write
    wr_reg(4'hC, 32'hA5C3_0F96, 1'b0, "R9 capture wr");
    idle(1, 4'hC, 1'b0, "R9 capture rd");

    // R10: counter write racing a tick; reload change after next underflow
    wr_reg(4'h0, 32'd2, 1'b0, "R10 reload");
    wr_reg(4'h4, 32'd1, 1'b0, "R10 counter");
    wr_reg(4'h8, 32'h20, 1'b1, "R10 ctrl");
    idle(3, 4'h4, 1'b1, "");
    wr_reg(4'h4, 32'd9, 1'b1, "R10 write vs tick");
    idle(1, 4'h4, 1'b1, "R10 after write");

    // R7: clear with bit8=1 keeps flag, clear with 0 drops it, collision keeps it
    wr_reg(4'h4, 32'd0, 1'b1, "R5 zero");
    wr_reg(4'h8, 32'h20, 1'b1, "R7 ctrl");
    idle(6, 4'h8, 1'b1, "R5 underflow");
    wr_reg(4'h8, 32'h120, 1'b1, "R7 keep");
    idle(1, 4'h8, 1'b1, "R7 keep");
    wr_reg(4'h8, 32'h020, 1'b1, "R7 clear");
    idle(1, 4'h8, 1'b1, "R7 cleared");
    hit = 1'b0;
    wr_reg(4'h4, 32'd0, 1'b1, "R7 setup");
    for (int i = 0; i < 200 && !hit; i++) begin
      if (m_cnt == 0 && m_pc == f_div(m_ctrl[2:0]) - 1) begin
        wr_reg(4'h8, 32'h020, 1'b1, "R7 collision");
        check(rdata[8], 1'b1, "R7 collision flag");
        hit = 1'b1;
      end else idle(1, 4'h8, 1'b1, "");
    end
    check({31'd0, hit}, 32'd1, "R7 collision reached");

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r, d;
      logic [3:0]  a;
      r = $urandom;
      a = 4'($urandom);
      d = (r[3:2] == 2'd0) ? $urandom : 32'($urandom % 6);
      if (a[3:2] == 2'd2) d = {$urandom, 8'h00} | 32'($urandom % 4) | (32'(r[5]) << 5) | (32'(r[6]) << 8);
      step(r[9:7] == 3'd0, 1'b1, a, d, r[12:10] != 3'd0, "");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule